// File: doc/BRIEF.md
# SIMD Scalar Multiply-Long Unit

This block runs one packed widening multiply for each accepted instruction. Each lane of a 64-bit source register is multiplied by a single scalar lane taken from a second 64-bit register. The double-width products are packed into a 128-bit destination. That destination is a pair of neighbouring registers in a 32-entry, 64-bit register file that the block owns.

The 32-bit instruction word carries the following fields:
- the element size;
- signed or unsigned operation;
- the register numbers;
- the scalar lane index.

The scalar register number and the lane index are packed differently for 16-bit and 32-bit elements. Encodings with a reserved size, or with an odd destination number, write nothing. They are reported on status outputs that are valid together with the completion pulse.

The register file has a load port and a combinational read port. These are used to set up operands and to read results. Instructions are issued with a valid/ready handshake. Each accepted instruction produces exactly one single-cycle `done` pulse.

Top module: `lane_scale_widen`

## Requirements
- R1: The size field sits in instruction bits [21:20]. The value 01 selects four 16-bit lanes with 32-bit products. The value 10 selects two 32-bit lanes with 64-bit products.
- R2: Size 11 raises `related_flag`. Size 00 raises `undef_flag`. In both cases no register is written, and the two flags are never raised together.
- R3: If bit 0 of the destination number (instruction bit 12) is 1 and the size is not 11, `undef_flag` is raised and no register is written.
- R4: The first source register is {bit 7, bits [19:16]} and the destination number is {bit 22, bits [15:12]}. The low 64 bits of the result go to register (destination with bit 0 cleared) and the high 64 bits go to the register above it.
- R5: For 16-bit elements, the scalar register is bits [2:0] zero-extended, and the lane index is {bit 5, bit 3}, which selects lanes 0 to 3.
- R6: For 32-bit elements, the scalar register is bits [3:0] zero-extended, and the lane index is bit 5, which selects lanes 0 or 1.
- R7: Bit 24 set means both operands are zero-extended. Bit 24 clear means both are sign-extended, so the most negative values multiply correctly.
- R8: Result lane e holds the low 2×esize bits of (source lane e × scalar), placed at bits [e·2·esize +: 2·esize].
- R9: `issue_ready` is high only while the unit is idle, and an instruction is accepted when `issue_valid` and `issue_ready` are both high. `done` is high for exactly one cycle per accepted instruction. The flags are valid with `done` and hold until the next `done`.
- R10: `done` rises at the second rising clock edge after the accepting edge, and the written registers are readable from that point on.
- R11: A load through `rf_we` writes `rf_wdata` into register `rf_waddr` at the clock edge. `rf_rdata` shows register `rf_raddr` combinationally, and every register reads zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Unit idle, ready to accept |
| issue_insn | input | 32 | Instruction word |
| done | output | 1 | One-cycle completion pulse |
| undef_flag | output | 1 | Last instruction was an undefined encoding |
| related_flag | output | 1 | Last instruction belongs to a related encoding |
| rf_we | input | 1 | Register load enable |
| rf_waddr | input | 5 | Register load address |
| rf_wdata | input | 64 | Register load data |
| rf_raddr | input | 5 | Register read address |
| rf_rdata | output | 64 | Register read data |

## Verification
Each signedness is driven at every lane index for both element sizes, with the selected scalar and the source lanes at the most negative value. A unit that sign-extends unsigned data, or zero-extends signed data, gives the wrong upper product bits there. A unit that takes the index from the wrong bit, or takes the scalar register from the full Vm field at 16-bit size, picks up a different lane or register whose value differs on purpose.

Reserved sizes and odd destinations are mixed into random traffic. A unit that wrote anyway would change the register pair that is read back afterwards. A unit with a wrong pipeline depth misses the exact `done` cycle that is expected.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  localparam int XLEN       = 64;
  localparam int NREGS      = 32;
  localparam int RAW        = $clog2(NREGS);
  localparam int HALF_W     = 16;
  localparam int WORD_W     = 32;
  localparam int HALF_LANES = XLEN / HALF_W;
  localparam int WORD_LANES = XLEN / WORD_W;

  typedef enum logic [1:0] {
    ES_NONE  = 2'b00,
    ES_HALF  = 2'b01,
    ES_WORD  = 2'b10,
    ES_OTHER = 2'b11
  } esize_e;

  typedef struct packed {
    esize_e         size;
    logic           uns;
    logic [RAW-1:0] src_a;
    logic [RAW-1:0] scal_reg;
    logic [RAW-1:0] dst;
    logic [1:0]     idx;
    logic           undef;
    logic           related;
  } dec_t;

  function automatic dec_t decode_insn(input logic [31:0] w);
    dec_t r;
    r.size  = esize_e'(w[21:20]);
    r.uns   = w[24];
    r.src_a = {w[7], w[19:16]};
    r.dst   = {w[22], w[15:12]};
    if (w[21:20] == 2'b01) begin
      r.scal_reg = {2'b00, w[2:0]};
      r.idx      = {w[5], w[3]};
    end else begin
      r.scal_reg = {1'b0, w[3:0]};
      r.idx      = {1'b0, w[5]};
    end
    r.related = (w[21:20] == 2'b11);
    r.undef   = !r.related && ((w[21:20] == 2'b00) || w[12]);
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] pick_scalar(input logic [XLEN-1:0] r,
                                                    input esize_e s,
                                                    input logic [1:0] idx);
    if (s == ES_HALF) return {{(WORD_W-HALF_W){1'b0}}, r[idx*HALF_W +: HALF_W]};
    return r[idx[0]*WORD_W +: WORD_W];
  endfunction

  function automatic logic [2*HALF_W-1:0] widen_half(input logic [HALF_W-1:0] a,
                                                     input logic [HALF_W-1:0] b,
                                                     input logic uns);
    logic signed [HALF_W:0]     ea, eb;
    logic signed [2*HALF_W+1:0] p;
    ea = {uns ? 1'b0 : a[HALF_W-1], a};
    eb = {uns ? 1'b0 : b[HALF_W-1], b};
    p  = ea * eb;
    return p[2*HALF_W-1:0];
  endfunction

  function automatic logic [2*WORD_W-1:0] widen_word(input logic [WORD_W-1:0] a,
                                                     input logic [WORD_W-1:0] b,
                                                     input logic uns);
    logic signed [WORD_W:0]     ea, eb;
    logic signed [2*WORD_W+1:0] p;
    ea = {uns ? 1'b0 : a[WORD_W-1], a};
    eb = {uns ? 1'b0 : b[WORD_W-1], b};
    p  = ea * eb;
    return p[2*WORD_W-1:0];
  endfunction
endpackage

// File: rtl/lsw_regfile.sv
module lsw_regfile #(
  parameter int NR = 32,
  parameter int W  = 64,
  localparam int AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [W-1:0]  ext_wdata,
  input  logic          pair_we,
  input  logic [AW-2:0] pair_q,
  input  logic [2*W-1:0] pair_data,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data,
  input  logic [AW-1:0] rc_addr,
  output logic [W-1:0]  rc_data
);
  logic [W-1:0] mem [NR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < NR; i++) begin
        if (pair_we && (i[AW-1:1] == pair_q))
          mem[i] <= i[0] ? pair_data[2*W-1:W] : pair_data[W-1:0];
        else if (ext_we && (i[AW-1:0] == ext_addr))
          mem[i] <= ext_wdata;
      end
    end
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
  assign rc_data = mem[rc_addr];

  // R4: low half lands in the even register, high half in the odd one
  assert_pair_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_we |=> mem[{$past(pair_q), 1'b0}] == $past(pair_data[W-1:0]));
  assert_pair_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_we |=> mem[{$past(pair_q), 1'b1}] == $past(pair_data[2*W-1:W]));
endmodule

// File: rtl/lsw_decode.sv
module lsw_decode
  import lsw_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);
  always_comb dec = decode_insn(insn);
endmodule

// File: rtl/lsw_lanes.sv
module lsw_lanes
  import lsw_pkg::*;
(
  input  esize_e            size,
  input  logic              uns,
  input  logic [XLEN-1:0]   vec,
  input  logic [WORD_W-1:0] scal,
  output logic [2*XLEN-1:0] prod
);
  logic [2*XLEN-1:0] half_p, word_p;

  for (genvar g = 0; g < HALF_LANES; g++) begin : g_half
    assign half_p[g*2*HALF_W +: 2*HALF_W] =
      widen_half(vec[g*HALF_W +: HALF_W], scal[HALF_W-1:0], uns);
  end

  for (genvar g = 0; g < WORD_LANES; g++) begin : g_word
    assign word_p[g*2*WORD_W +: 2*WORD_W] =
      widen_word(vec[g*WORD_W +: WORD_W], scal, uns);
  end

  assign prod = (size == ES_HALF) ? half_p : word_p;
endmodule

// File: rtl/lane_scale_widen.sv
module lane_scale_widen
  import lsw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  output logic            issue_ready,
  input  logic [31:0]     issue_insn,
  output logic            done,
  output logic            undef_flag,
  output logic            related_flag,
  input  logic            rf_we,
  input  logic [RAW-1:0]  rf_waddr,
  input  logic [XLEN-1:0] rf_wdata,
  input  logic [RAW-1:0]  rf_raddr,
  output logic [XLEN-1:0] rf_rdata
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} st_e;

  st_e               state;
  logic [31:0]       insn_q;
  dec_t              dec;
  logic [XLEN-1:0]   rd_a, rd_b;
  logic [XLEN-1:0]   op_vec;
  logic [WORD_W-1:0] op_scal;
  esize_e            st_size;
  logic              st_uns, st_undef, st_related;
  logic [RAW-2:0]    st_q;
  logic [2*XLEN-1:0] prod;
  logic              done_q, undef_q, related_q;

  // named events for checking
  logic accept, wb_commit;
  assign issue_ready = (state == ST_IDLE);
  assign accept      = issue_valid && issue_ready;
  assign wb_commit   = (state == ST_WRITE) && !st_undef && !st_related;

  lsw_decode u_dec (.insn(insn_q), .dec(dec));

  lsw_regfile #(.NR(NREGS), .W(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ext_we(rf_we), .ext_addr(rf_waddr), .ext_wdata(rf_wdata),
    .pair_we(wb_commit), .pair_q(st_q), .pair_data(prod),
    .ra_addr(dec.src_a), .ra_data(rd_a),
    .rb_addr(dec.scal_reg), .rb_data(rd_b),
    .rc_addr(rf_raddr), .rc_data(rf_rdata)
  );

  lsw_lanes u_lanes (
    .size(st_size), .uns(st_uns), .vec(op_vec), .scal(op_scal), .prod(prod)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      insn_q     <= '0;
      op_vec     <= '0;
      op_scal    <= '0;
      st_size    <= ES_NONE;
      st_uns     <= 1'b0;
      st_undef   <= 1'b0;
      st_related <= 1'b0;
      st_q       <= '0;
      done_q     <= 1'b0;
      undef_q    <= 1'b0;
      related_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          insn_q <= issue_insn;
          state  <= ST_READ;
        end
        ST_READ: begin
          op_vec     <= rd_a;
          op_scal    <= pick_scalar(rd_b, dec.size, dec.idx);
          st_size    <= dec.size;
          st_uns     <= dec.uns;
          st_q       <= dec.dst[RAW-1:1];
          st_undef   <= dec.undef;
          st_related <= dec.related;
          state      <= ST_WRITE;
        end
        ST_WRITE: begin
          done_q    <= 1'b1;
          undef_q   <= st_undef;
          related_q <= st_related;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done         = done_q;
  assign undef_flag   = undef_q;
  assign related_flag = related_q;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !issue_ready);
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##2 done);
  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({undef_flag, related_flag}));
  assert_write_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wb_commit) == !(undef_flag || related_flag)));
endmodule

// File: tb/lane_scale_widen_test.sv
module lane_scale_widen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic        issue_ready;
  logic [31:0] issue_insn = '0;
  logic        done, undef_flag, related_flag;
  logic        rf_we = 1'b0;
  logic [4:0]  rf_waddr = '0;
  logic [63:0] rf_wdata = '0;
  logic [4:0]  rf_raddr = '0;
  logic [63:0] rf_rdata;

  int checks = 0;
  int fails  = 0;
  logic [63:0] mdl [32];

  always #4 clk = ~clk;

  lane_scale_widen uut (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [63:0] v, input int w, input bit u);
    logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 1);
    v = v & m;
    if (!u && v[w-1]) v = v | ~m;
    return v;
  endfunction

  function automatic logic [127:0] ref_result(input logic [31:0] w, input logic [63:0] va, input logic [63:0] vb);
    int ew, lanes, ix;
    bit u = w[24];
    logic [63:0] s, a, p;
    logic [127:0] r = '0;
    if (w[21:20] == 2'b01) begin ew = 16; lanes = 4; ix = {w[5], w[3]}; end
    else begin ew = 32; lanes = 2; ix = w[5]; end
    s = sx(va >> 0, 64, 1'b1);
    s = sx(vb >> (ix * ew), ew, u);
    for (int e = 0; e < lanes; e++) begin
      a = sx(va >> (e * ew), ew, u);
      p = a * s;
      p = sx(p, 2 * ew, 1'b1);
      r = r | (128'(p) << (e * 2 * ew));
    end
    return r;
  endfunction

  function automatic logic [31:0] mk(input bit u, input bit d, input logic [1:0] sz, input logic [3:0] vn,
                                     input logic [3:0] vd, input bit n, input bit m, input logic [3:0] vm);
    return {7'b1111001, u, 1'b1, d, sz, vn, vd, 4'b1010, n, 1'b1, m, 1'b0, vm};
  endfunction

  task automatic load_reg(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = a; rf_wdata = d;
    @(negedge clk);
    rf_we = 1'b0;
    mdl[a] = d;
  endtask

  task automatic read_reg(input logic [4:0] a, output logic [63:0] d);
    @(negedge clk);
    rf_raddr = a;
    #1 d = rf_rdata;
  endtask

  task automatic run(input logic [31:0] w);
    int lat;
    logic [1:0] sz = w[21:20];
    logic [4:0] dst = {w[22], w[15:12]};
    logic [4:0] src = {w[7], w[19:16]};
    logic [4:0] scr = (sz == 2'b01) ? {2'b00, w[2:0]} : {1'b0, w[3:0]};
    bit exp_rel = (sz == 2'b11);
    bit exp_und = !exp_rel && (sz == 2'b00 || w[12]);
    logic [127:0] res;
    logic [63:0] lo, hi;
    logic [4:0] base = {dst[4:1], 1'b0};
    @(negedge clk);
    issue_valid = 1'b1; issue_insn = w;
    @(posedge clk);
    @(negedge clk);
    issue_valid = 1'b0;
    chk(issue_ready == 1'b0, "R9 busy after accept", 128'(issue_ready), 128'(0));
    lat = 0;
    while (!done) begin @(negedge clk); lat++; end
    chk(lat == 2, "R10 latency", 128'(lat), 128'(2));
    chk(related_flag == exp_rel && undef_flag == exp_und, "R2/R3 flags",
        128'({related_flag, undef_flag}), 128'({exp_rel, exp_und}));
    if (!exp_rel && !exp_und) begin
      res = ref_result(w, mdl[src], mdl[scr]);
      mdl[base] = res[63:0];
      mdl[base + 5'd1] = res[127:64];
    end
    read_reg(base, lo);
    chk(lo == mdl[base], "R8/R4 low half (R1 R5 R6 R7)", 128'(lo), 128'(mdl[base]));
    chk(done == 1'b0, "R9 done single cycle", 128'(done), 128'(0));
    read_reg(base + 5'd1, hi);
    chk(hi == mdl[base + 5'd1], "R8/R4 high half", 128'(hi), 128'(mdl[base + 5'd1]));
  endtask

  function automatic logic [63:0] rnd64();
    logic [63:0] v = {$urandom, $urandom};
    case ($urandom % 6)
      0: v = 64'h8000_8000_8000_8000;
      1: v = 64'h8000_0000_8000_0000;
      2: v = '1;
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=hang expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] v;
    void'($urandom(32'd1357));
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(issue_ready && !done && !undef_flag && !related_flag, "R9 reset state",
        128'({issue_ready, done, undef_flag, related_flag}), 128'(4'b1000));
    read_reg(5'd9, v);
    chk(v == '0, "R11 reset register", 128'(v), 128'(0));
    load_reg(5'd9, 64'h0123_4567_89AB_CDEF);
    read_reg(5'd9, v);
    chk(v == 64'h0123_4567_89AB_CDEF, "R11 load and read", 128'(v), 128'(64'h0123_4567_89AB_CDEF));

    // directed: every index, both sizes, both signedness, most negative operands
    for (int sz = 1; sz <= 2; sz++) begin
      for (int u = 0; u < 2; u++) begin
        for (int ix = 0; ix < (sz == 1 ? 4 : 2); ix++) begin
          if (sz == 1) begin
            load_reg(5'd4, 64'h8000_7FFF_FFFF_8000);
            load_reg(5'd6, 64'h0003_0005_0007_0009 & ~(64'hFFFF << (ix * 16)) | (64'h8000 << (ix * 16)));
            load_reg(5'd14, 64'h1111_2222_3333_4444);
            run(mk(u[0], 1'b0, 2'b01, 4'd4, 4'd10, 1'b0, ix[1], {ix[0], 3'd6}));
          end else begin
            load_reg(5'd5, 64'h8000_0000_7FFF_FFFF);
            load_reg(5'd13, 64'h0000_0003_0000_0003 & ~(64'hFFFF_FFFF << (ix * 32)) | (64'h8000_0000 << (ix * 32)));
            run(mk(u[0], 1'b1, 2'b10, 4'd5, 4'd2, 1'b0, ix[0], 4'd13));
          end
        end
      end
    end
    // directed: reserved sizes and odd destination
    run(mk(1'b0, 1'b0, 2'b00, 4'd4, 4'd10, 1'b0, 1'b0, 4'd6));
    run(mk(1'b0, 1'b0, 2'b11, 4'd4, 4'd10, 1'b0, 1'b0, 4'd6));
    run(mk(1'b0, 1'b0, 2'b01, 4'd4, 4'd11, 1'b0, 1'b0, 4'd6));

    // random traffic
    for (int k = 0; k < 300; k++) begin
      int r = $urandom % 10;
      logic [1:0] sz = (r == 0) ? 2'b00 : (r == 1) ? 2'b11 : (r < 6) ? 2'b01 : 2'b10;
      logic [31:0] w = $urandom;
      if (($urandom % 8) != 0) w[12] = 1'b0;
      load_reg({w[7], w[19:16]}, rnd64());
      load_reg($urandom % 32, rnd64());
      load_reg(5'(w[3:0]), rnd64());
      load_reg({2'b00, w[2:0]}, rnd64());
      run(mk(w[24], w[22], sz, w[19:16], w[15:12], w[7], w[5], w[3:0]));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule